// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the register file of a 64-source interrupt controller, reached over a simple 32-bit, word-addressed read/write bus. It holds the control word, the normal-request threshold, and the per-source enable, type (normal or fast) and 4-bit priority state. It also tracks a pending bit for every source, driven by edges on the source inputs and by software force writes.

Two built-in arbiters turn that state into results. The normal arbiter picks the eligible normal source with the highest priority, and the fast arbiter picks the lowest-numbered eligible fast source. Software reads these results through two status words. Each such read also clears the pending bit of the source it reports. The block drives a normal and a fast request line from the same state.

The 64-bit vectors appear to software as separate high and low words. Enables can also be set or cleared one source at a time by number. A window of vector-address words is decoded: writes to it are dropped, and its first word reads as a constant.

Top module: `intc_csr`

## Requirements
- R1: After reset, pending, enable, type, control and all priority words are zero, and the threshold word reads 31. Both status words read 0xFFFFFFFF and both request lines are low.
- R2: A read presented in cycle N shows on bus_rdata after the clock edge that ends cycle N. bus_rdata holds its value when no read is presented.
- R3: Only control bits 24, 22, 21, 20, 19 and 18 are stored, and all other control bits read zero. The threshold word (offset 1) keeps bits 4:0 only.
- R4: A write to offset 2 sets the enable bit numbered by wdata[5:0]. A write to offset 3 clears that bit. Both offsets read zero.
- R5: Offsets 4/5 hold enable bits 63:32 and 31:0, and offsets 6/7 hold type bits 63:32 and 31:0 (type 1 = fast). A write replaces only that half.
- R6: Priority offset 15-k holds sources 8k..8k+7, with bits 4j+3:4j holding the priority of source 8k+j.
- R7: A rising source input sets its pending bit, and a falling one clears it. An edge takes precedence over a bus clear or force in the same cycle. Offsets 18/19 read raw pending bits 63:32 and 31:0.
- R8: A write to offset 20/21 replaces pending bits 63:32 / 31:0. Both offsets read zero.
- R9: Offsets 22/23 read pending AND enable AND NOT type (high/low), and offsets 24/25 read pending AND enable AND type (high/low).
- R10: Offset 16 returns {index in bits 21:16, priority in bits 3:0} of the eligible normal source with the highest priority, with ties going to the higher index. It returns 0xFFFFFFFF if no such source exists. A read that reports a source clears that source's pending bit.
- R11: Offset 17 returns the lowest index among eligible fast sources, or 0xFFFFFFFF if there is none. A read that reports a source clears that source's pending bit.
- R12: fst_req is high when any eligible fast source exists. nrm_req is high when an eligible normal source exists and either the threshold is 31 or the highest eligible priority exceeds the threshold.
- R13: Writes to offsets 16-19, 22-25, the vector window (word offsets 0x40-0xBF) and unmapped offsets change nothing. Word 0x40 reads 4, and other vector and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| src_level | input | 64 | Source input levels |
| nrm_req | output | 1 | Normal interrupt request |
| fst_req | output | 1 | Fast interrupt request |

## Verification
A status read clears the reported source's pending bit at the same edge where a source edge can set or clear it, so the two updates can land in one cycle. The bench provokes this by forcing a source pending while its input is low. It then raises that input in the very cycle the normal status word is read. The read must still report that source, and a following raw-pending read must show the bit still set, because the rising edge wins. A repeat read with the input held steady must then clear it.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int SRC_N      = 64;
    localparam int DATA_W     = 32;
    localparam int PRIO_W     = 4;
    localparam int MASK_W     = 5;
    localparam int ADDR_W     = 10;
    localparam int IDX_W      = $clog2(SRC_N);
    localparam int PRIO_PER_W = DATA_W / PRIO_W;
    localparam int PRIO_WORDS = SRC_N / PRIO_PER_W;
    localparam int PW_W       = $clog2(PRIO_WORDS);

    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h017C_0000;
    localparam logic [DATA_W-1:0] NO_SRC     = '1;
    localparam logic [DATA_W-1:0] VEC0_VALUE = 32'd4;
    localparam logic [ADDR_W-1:0] VEC_FIRST  = 10'h040;
    localparam logic [ADDR_W-1:0] VEC_LAST   = 10'h0BF;

    typedef enum logic [4:0] {
        K_NONE, K_CTRL, K_THRESH, K_ENSET, K_ENCLR, K_ENHI, K_ENLO,
        K_TYHI, K_TYLO, K_PRIO, K_NSTAT, K_FSTAT, K_RAWHI, K_RAWLO,
        K_FRCHI, K_FRCLO, K_NPHI, K_NPLO, K_FPHI, K_FPLO, K_VEC0, K_VEC
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e       kind;
        logic [PW_W-1:0] pword;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } nrm_res_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } fst_res_t;

    function automatic dec_t intc_decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.kind  = K_NONE;
        d.pword = '0;
        if (a < 10'd32) begin
            case (a[4:0])
                5'd0:  d.kind = K_CTRL;
                5'd1:  d.kind = K_THRESH;
                5'd2:  d.kind = K_ENSET;
                5'd3:  d.kind = K_ENCLR;
                5'd4:  d.kind = K_ENHI;
                5'd5:  d.kind = K_ENLO;
                5'd6:  d.kind = K_TYHI;
                5'd7:  d.kind = K_TYLO;
                5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15: begin
                    d.kind  = K_PRIO;
                    d.pword = ~a[PW_W-1:0];
                end
                5'd16: d.kind = K_NSTAT;
                5'd17: d.kind = K_FSTAT;
                5'd18: d.kind = K_RAWHI;
                5'd19: d.kind = K_RAWLO;
                5'd20: d.kind = K_FRCHI;
                5'd21: d.kind = K_FRCLO;
                5'd22: d.kind = K_NPHI;
                5'd23: d.kind = K_NPLO;
                5'd24: d.kind = K_FPHI;
                5'd25: d.kind = K_FPLO;
                default: d.kind = K_NONE;
            endcase
        end else if (a == VEC_FIRST) begin
            d.kind = K_VEC0;
        end else if (a > VEC_FIRST && a <= VEC_LAST) begin
            d.kind = K_VEC;
        end
        return d;
    endfunction

endpackage

// File: rtl/intc_pend_track.sv
module intc_pend_track #(
    parameter int SRC_N  = intc_pkg::SRC_N,
    parameter int DATA_W = intc_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  src_level,
    input  logic              frc_hi_we,
    input  logic              frc_lo_we,
    input  logic [DATA_W-1:0] frc_data,
    input  logic [SRC_N-1:0]  clr_vec,
    output logic [SRC_N-1:0]  pend
);
    localparam int HALF = SRC_N / 2;

    logic [SRC_N-1:0] src_q;

    // Per-source next state: bus effect first, then edges override it.
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        logic bus_val;
        logic rise;
        logic fall;

        always_comb begin
            bus_val = pend[i] & ~clr_vec[i];
            if (i >= HALF) begin
                if (frc_hi_we) bus_val = frc_data[(i - HALF) % DATA_W];
            end else begin
                if (frc_lo_we) bus_val = frc_data[i % DATA_W];
            end
            rise = src_level[i] & ~src_q[i];
            fall = ~src_level[i] & src_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[i] <= 1'b0;
                pend[i]  <= 1'b0;
            end else begin
                src_q[i] <= src_level[i];
                pend[i]  <= (bus_val | rise) & ~fall;
            end
        end
    end

endmodule

// File: rtl/intc_norm_arb.sv
module intc_norm_arb
    import intc_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int PW = PRIO_W
) (
    input  logic [N-1:0]    elig,
    input  logic [N*PW-1:0] prio_flat,
    output nrm_res_t        res
);
    // Ascending scan with >= so that the higher index wins a tie.
    always_comb begin
        res = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!res.valid || prio_flat[i*PW +: PW] >= res.prio)) begin
                res.valid = 1'b1;
                res.idx   = i[IDX_W-1:0];
                res.prio  = prio_flat[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/intc_fast_pick.sv
module intc_fast_pick
    import intc_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic [N-1:0] elig,
    output fst_res_t     res
);
    // Descending scan: the last hit is the lowest index.
    always_comb begin
        res = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                res.valid = 1'b1;
                res.idx   = i[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/intc_csr.sv
module intc_csr
    import intc_pkg::*;
#(
    parameter int N_SRC = SRC_N,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N_SRC-1:0] src_level,
    output logic          nrm_req,
    output logic          fst_req
);
    localparam int HALF = N_SRC / 2;

    dec_t dec;
    logic wr_go;
    logic rd_go;

    logic [DW-1:0]                    ctrl_q;
    logic [MASK_W-1:0]                mask_q;
    logic [N_SRC-1:0]                 en_q;
    logic [N_SRC-1:0]                 type_q;
    logic [PRIO_WORDS-1:0][DW-1:0]    prio_q;
    logic [N_SRC-1:0]                 pend_q;
    logic [N_SRC-1:0]                 clr_vec;
    logic [N_SRC-1:0]                 nelig;
    logic [N_SRC-1:0]                 felig;
    nrm_res_t                         nres;
    fst_res_t                         fres;
    logic [DW-1:0]                    nstat_word;
    logic [DW-1:0]                    rd_val;

    assign dec   = intc_decode(bus_addr);
    assign wr_go = bus_sel & bus_wr;
    assign rd_go = bus_sel & ~bus_wr;

    // Configuration state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '1;
            en_q   <= '0;
            type_q <= '0;
            prio_q <= '0;
        end else if (wr_go) begin
            case (dec.kind)
                K_CTRL:   ctrl_q <= bus_wdata & CTRL_WMASK;
                K_THRESH: mask_q <= bus_wdata[MASK_W-1:0];
                K_ENSET:  en_q[bus_wdata[IDX_W-1:0]] <= 1'b1;
                K_ENCLR:  en_q[bus_wdata[IDX_W-1:0]] <= 1'b0;
                K_ENHI:   en_q[N_SRC-1:HALF]   <= bus_wdata;
                K_ENLO:   en_q[HALF-1:0]       <= bus_wdata;
                K_TYHI:   type_q[N_SRC-1:HALF] <= bus_wdata;
                K_TYLO:   type_q[HALF-1:0]     <= bus_wdata;
                K_PRIO:   prio_q[dec.pword]    <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Eligibility views
    assign nelig = pend_q & en_q & ~type_q;
    assign felig = pend_q & en_q & type_q;

    intc_norm_arb #(.N(N_SRC), .PW(PRIO_W)) u_narb (
        .elig      (nelig),
        .prio_flat (prio_q),
        .res       (nres)
    );

    intc_fast_pick #(.N(N_SRC)) u_fpick (
        .elig (felig),
        .res  (fres)
    );

    // Status-read side effect: clear the reported source
    always_comb begin
        clr_vec = '0;
        if (rd_go && dec.kind == K_NSTAT && nres.valid) clr_vec[nres.idx] = 1'b1;
        if (rd_go && dec.kind == K_FSTAT && fres.valid) clr_vec[fres.idx] = 1'b1;
    end

    intc_pend_track #(.SRC_N(N_SRC), .DATA_W(DW)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .src_level (src_level),
        .frc_hi_we (wr_go && dec.kind == K_FRCHI),
        .frc_lo_we (wr_go && dec.kind == K_FRCLO),
        .frc_data  (bus_wdata),
        .clr_vec   (clr_vec),
        .pend      (pend_q)
    );

    assign nstat_word = (DW'(nres.idx) << 16) | DW'(nres.prio);

    // Read mux
    always_comb begin
        rd_val = '0;
        case (dec.kind)
            K_CTRL:   rd_val = ctrl_q;
            K_THRESH: rd_val = DW'(mask_q);
            K_ENHI:   rd_val = en_q[N_SRC-1:HALF];
            K_ENLO:   rd_val = en_q[HALF-1:0];
            K_TYHI:   rd_val = type_q[N_SRC-1:HALF];
            K_TYLO:   rd_val = type_q[HALF-1:0];
            K_PRIO:   rd_val = prio_q[dec.pword];
            K_NSTAT:  rd_val = nres.valid ? nstat_word : NO_SRC;
            K_FSTAT:  rd_val = fres.valid ? DW'(fres.idx) : NO_SRC;
            K_RAWHI:  rd_val = pend_q[N_SRC-1:HALF];
            K_RAWLO:  rd_val = pend_q[HALF-1:0];
            K_NPHI:   rd_val = nelig[N_SRC-1:HALF];
            K_NPLO:   rd_val = nelig[HALF-1:0];
            K_FPHI:   rd_val = felig[N_SRC-1:HALF];
            K_FPLO:   rd_val = felig[HALF-1:0];
            K_VEC0:   rd_val = VEC0_VALUE;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (rd_go) bus_rdata <= rd_val;
    end

    // Request lines
    assign fst_req = fres.valid;
    assign nrm_req = nres.valid && ((mask_q == '1) || (MASK_W'(nres.prio) > mask_q));

endmodule

// File: rtl/intc_csr_chk.sv
module intc_csr_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SRC_N-1:0]  src_level,
    input logic [SRC_N-1:0]  pend_q,
    input logic [SRC_N-1:0]  en_q,
    input logic [SRC_N-1:0]  type_q,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [MASK_W-1:0] mask_q,
    input logic              nrm_req,
    input logic              fst_req
);
    logic [SRC_N-1:0] src_d;
    logic [SRC_N-1:0] rise_d;
    logic [SRC_N-1:0] fall_d;
    logic             rd;
    logic             wr;
    logic             ro_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_d  <= '0;
            rise_d <= '0;
            fall_d <= '0;
        end else begin
            src_d  <= src_level;
            rise_d <= src_level & ~src_d;
            fall_d <= ~src_level & src_d;
        end
    end

    assign rd = bus_sel & ~bus_wr;
    assign wr = bus_sel & bus_wr;
    assign ro_addr = (bus_addr >= 10'd16 && bus_addr <= 10'd19) ||
                     (bus_addr >= 10'd22 && bus_addr <= 10'd25) ||
                     (bus_addr >= VEC_FIRST && bus_addr <= VEC_LAST);

    AST_CTRL_RDMASK: assert property (@(posedge clk) disable iff (rst)
        rd && bus_addr == 10'd0 |=> (bus_rdata & ~CTRL_WMASK) == '0); // R3
    AST_NUM_RDZERO: assert property (@(posedge clk) disable iff (rst)
        rd && (bus_addr == 10'd2 || bus_addr == 10'd3) |=> bus_rdata == '0); // R4
    AST_FORCE_RDZERO: assert property (@(posedge clk) disable iff (rst)
        rd && (bus_addr == 10'd20 || bus_addr == 10'd21) |=> bus_rdata == '0); // R8
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        rise_d != '0 |-> (pend_q & rise_d) == rise_d); // R7
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        fall_d != '0 |-> (pend_q & fall_d) == '0); // R7
    AST_NSTAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd && bus_addr == 10'd16 |=> (bus_rdata == NO_SRC) ||
            !pend_q[bus_rdata[16 +: IDX_W]] || rise_d[bus_rdata[16 +: IDX_W]]); // R10
    AST_FSTAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd && bus_addr == 10'd17 |=> (bus_rdata == NO_SRC) ||
            !pend_q[bus_rdata[IDX_W-1:0]] || rise_d[bus_rdata[IDX_W-1:0]]); // R11
    AST_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pend_q & en_q) == '0 |-> !nrm_req && !fst_req); // R12
    AST_RO_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr && ro_addr |=> $stable(en_q) && $stable(type_q) && $stable(ctrl_q) && $stable(mask_q)); // R13
    AST_VEC_CONST: assert property (@(posedge clk) disable iff (rst)
        rd && bus_addr == VEC_FIRST |=> bus_rdata == VEC0_VALUE); // R13

endmodule

bind intc_csr intc_csr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .src_level (src_level),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .type_q    (type_q),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask_q),
    .nrm_req   (nrm_req),
    .fst_req   (fst_req)
);

// File: tb/intc_csr_bench.sv
`timescale 1ns/1ps
module intc_csr_bench;
    import intc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [SRC_N-1:0]  src_level = '0;
    logic              nrm_req;
    logic              fst_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic              rd_seen;

    always #4 clk = ~clk;

    intc_csr u_intc_csr (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_level(src_level), .nrm_req(nrm_req), .fst_req(fst_req)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: a read accepted at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_seen <= rst ? 1'b0 : (bus_sel && !bus_wr);

    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (exp_q.size() == 0) chk("scoreboard underrun", 32'd1, 32'd0);
                else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr32(input int a, input logic [DATA_W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd32(input int a, input logic [DATA_W-1:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 nrm_req after reset", 32'(nrm_req), 32'd0);
        chk("R1 fst_req after reset", 32'(fst_req), 32'd0);
        rd32(0, 32'h0, "R1 control reset");
        rd32(1, 32'd31, "R1 threshold reset");
        rd32(5, 32'h0, "R1 enable reset");
        rd32(19, 32'h0, "R1 pending reset");
        rd32(15, 32'h0, "R1 priority reset");
        rd32(16, NO_SRC, "R1 normal status empty");
        rd32(17, NO_SRC, "R1 fast status empty");

        // R2 hold: idle cycles keep the last read value
        idle(2);
        chk("R2 rdata held", bus_rdata, NO_SRC);

        // R3 control and threshold widths
        wr32(0, 32'hFFFF_FFFF);
        rd32(0, 32'h017C_0000, "R3 control writable bits");
        wr32(1, 32'hFFFF_FFE3);
        rd32(1, 32'h0000_0003, "R3 threshold five bits");

        // R4 by-number enable
        wr32(2, 32'h0000_0145);
        wr32(2, 32'h0000_0028);
        rd32(5, 32'h0000_0020, "R4 set by number low");
        rd32(4, 32'h0000_0100, "R4 set by number high");
        rd32(2, 32'h0, "R4 set-number reads zero");
        wr32(3, 32'h0000_00C5);
        rd32(5, 32'h0, "R4 clear by number");
        rd32(3, 32'h0, "R4 clear-number reads zero");

        // R5 halves
        wr32(4, 32'hA5A5_0000);
        rd32(4, 32'hA5A5_0000, "R5 enable high");
        rd32(5, 32'h0, "R5 enable low untouched");
        wr32(5, 32'hFFFF_FFFF);
        wr32(4, 32'hFFFF_FFFF);
        wr32(6, 32'h0000_0001);
        wr32(7, 32'h0000_0100);
        rd32(6, 32'h0000_0001, "R5 type high");
        rd32(7, 32'h0000_0100, "R5 type low");

        // R6 priority layout
        wr32(15, 32'h0000_0030);
        wr32(8, 32'h7000_0000);
        wr32(12, 32'h0007_0000);
        rd32(15, 32'h0000_0030, "R6 word for sources 0-7");
        rd32(8, 32'h7000_0000, "R6 word for sources 56-63");

        // R7 capture, R10 normal arbitration
        src_level[1] = 1'b1; src_level[3] = 1'b1;
        src_level[28] = 1'b1; src_level[63] = 1'b1;
        idle(1);
        rd32(19, 32'h1000_000A, "R7 raw pending low");
        rd32(18, 32'h8000_0000, "R7 raw pending high");
        rd32(16, 32'h003F_0007, "R10 tie to higher index");
        rd32(18, 32'h0, "R10 read cleared winner");
        rd32(16, 32'h001C_0007, "R10 next winner");
        rd32(16, 32'h0001_0003, "R10 priority order");
        rd32(16, 32'h0003_0000, "R10 priority zero source");
        rd32(16, NO_SRC, "R10 drained");
        rd32(19, 32'h0, "R10 pending drained");

        // R9 views, R11 fast pick
        src_level = '0;
        idle(1);
        src_level[8] = 1'b1; src_level[32] = 1'b1; src_level[40] = 1'b1;
        idle(1);
        chk("R12 fst_req with fast pending", 32'(fst_req), 32'd1);
        rd32(25, 32'h0000_0100, "R9 fast pending low");
        rd32(24, 32'h0000_0001, "R9 fast pending high");
        rd32(23, 32'h0, "R9 normal pending low");
        rd32(22, 32'h0000_0100, "R9 normal pending high");
        rd32(17, 32'd8, "R11 lowest fast index");
        rd32(17, 32'd32, "R11 next fast index");
        chk("R12 fst_req after drain", 32'(fst_req), 32'd0);
        rd32(17, NO_SRC, "R11 fast drained");

        // R12 threshold against priority
        wr32(1, 32'd31);
        chk("R12 threshold 31 passes prio 0", 32'(nrm_req), 32'd1);
        wr32(1, 32'd0);
        chk("R12 prio 0 not above 0", 32'(nrm_req), 32'd0);
        wr32(10, 32'h0000_0002);
        chk("R12 prio 2 above 0", 32'(nrm_req), 32'd1);
        wr32(1, 32'd2);
        chk("R12 prio 2 not above 2", 32'(nrm_req), 32'd0);
        wr32(1, 32'd1);
        chk("R12 prio 2 above 1", 32'(nrm_req), 32'd1);

        // R7 falling edge clears
        src_level[40] = 1'b0;
        idle(1);
        chk("R7 fall drops request", 32'(nrm_req), 32'd0);
        rd32(22, 32'h0, "R7 fall clears pending");

        // R8 force
        wr32(21, 32'h0000_00F0);
        rd32(19, 32'h0000_00F0, "R8 force low");
        rd32(21, 32'h0, "R8 force reads zero");
        wr32(20, 32'h0000_0001);
        rd32(18, 32'h0000_0001, "R8 force high");
        rd32(19, 32'h0000_00F0, "R8 low half kept");
        chk("R12 forced fast source", 32'(fst_req), 32'd1);

        // R13 ignored writes and vector window
        wr32(16, 32'hFFFF_FFFF);
        wr32(18, 32'hFFFF_FFFF);
        wr32(19, 32'h0);
        wr32(23, 32'hFFFF_FFFF);
        wr32(64, 32'hFFFF_FFFF);
        wr32(128, 32'h0);
        wr32(26, 32'h0);
        rd32(19, 32'h0000_00F0, "R13 raw pending unchanged");
        rd32(18, 32'h0000_0001, "R13 raw high unchanged");
        rd32(5, 32'hFFFF_FFFF, "R13 enable unchanged");
        rd32(1, 32'd1, "R13 threshold unchanged");
        rd32(64, 32'd4, "R13 vector word constant");
        rd32(65, 32'h0, "R13 other vector word");
        rd32(1023, 32'h0, "R13 unmapped read");

        // R7/R10 collision: status clear and rising edge in one cycle
        wr32(20, 32'h0);
        wr32(21, 32'h0000_0020);
        src_level[5] = 1'b1;
        rd32(16, 32'h0005_0000, "R10 collision report");
        rd32(19, 32'h0000_0020, "R7 rise beats status clear");
        rd32(16, 32'h0005_0000, "R10 repeat report");
        rd32(19, 32'h0, "R10 steady input cleared");

        idle(3);
        if (exp_q.size() != 0) chk("scoreboard leftover", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule